// File: doc/BRIEF.md
# Multi-Context Configuration Plane Selector

This block lets one tile of a reconfigurable fabric be time-multiplexed. Rather than holding a single configuration, it keeps one configuration word per context and, on each cycle, drives the tile's datapath controls with the word of the current context. A small space of hardware can therefore carry a larger schedule by spending time instead of area.

A context counter steps through the contexts in a fixed repeating order and wraps at a run-time programmed count of used contexts. That count may be anywhere from one up to the number of contexts built into the hardware. The counter value is widened into a one-hot select, and each output configuration bit is formed as the OR over all contexts of that context's stored bit ANDed with its select line. Every tile holds an identical counter and receives the same used-context count, so all tiles change context in the same cycle. While the fabric is stopped, the contexts are filled through a simple write port.

Top module: `ctx_plane_sel`

## Requirements
- R1: A synchronous reset returns the context code to 0, sets the used-context count to NUM_CTX, clears all stored words, and clears the configuration output to 0.
- R2: A write (ld_we high with run_en low) to binary index ld_ctx stores ld_word for that context, and that word is presented on cfg_out when that context is current.
- R3: With all NUM_CTX contexts in use and run_en high, ctx_code steps 0, 1, ..., NUM_CTX-1 and then back to 0.
- R4: With a used count U below NUM_CTX, ctx_code counts modulo U (with U=3: 0, 1, 2, 0).
- R5: With a used count of 1, ctx_code stays at 0 while running.
- R6: A used_val of 0 is taken as 1 and a used_val above NUM_CTX is taken as NUM_CTX.
- R7: A pulse on used_we sets ctx_code to 0 on the next cycle, even while run_en is high.
- R8: While run_en is low and used_we is low, ctx_code holds its value.
- R9: Writes issued while run_en is high leave every stored word unchanged.
- R10: Writes to an index of NUM_CTX or above leave every stored word unchanged.
- R11: cfg_out is registered: in the cycle after ctx_code holds value k, cfg_out equals the stored word of context k, chosen by AND/OR of stored bits with the one-hot select.
- R12: ctx_code always stays below the used-context count, so exactly one select line among the used contexts is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Fabric run enable; counter advances while high |
| ld_we | input | 1 | Configuration write strobe |
| ld_ctx | input | CTX_W | Binary context index for the write |
| ld_word | input | CFG_W | Configuration word to store |
| used_we | input | 1 | Strobe that loads a new used-context count |
| used_val | input | CNT_W | Requested number of used contexts (binary) |
| ctx_code | output | CTX_W | Current context code, shared in lockstep with other tiles |
| cfg_out | output | CFG_W | Registered configuration word for the tile |

## Verification
The hardest situation to reach from the ports is a write that must be dropped, either because the fabric is running or because the index lies beyond the built contexts, since the stored words are not visible directly. The bench builds the block with six contexts so that indices 6 and 7 exist on a three-bit index, issues such writes, then stops the fabric and walks the counter through every context, comparing each presented word with the value last legally written. A change of used count while running is also driven in the same cycle as a run step, to show the restart wins over the advance.

// File: rtl/ctx_plane_pkg.sv
package ctx_plane_pkg;

  // Requested used-context count mapped into the legal range 1..max_ctx (R6)
  function automatic int clamp_used(int req, int max_ctx);
    if (req <= 0) return 1;
    if (req > max_ctx) return max_ctx;
    return req;
  endfunction

  // True when the code is the final one before the wrap
  function automatic logic is_last(int code, int used);
    return (code + 1) >= used;
  endfunction

endpackage

// File: rtl/ctx_store.sv
module ctx_store #(
  parameter int NUM_CTX = 4,
  parameter int CFG_W   = 16,
  parameter int CTX_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic                            run_en,
  input  logic [CTX_W-1:0]                idx,
  input  logic [CFG_W-1:0]                wdata,
  output logic [NUM_CTX-1:0][CFG_W-1:0]   words,
  output logic                            wr_fire
);
  localparam logic [CTX_W:0] IDX_LIMIT = (CTX_W+1)'(NUM_CTX);

  logic idx_ok;
  assign idx_ok  = ({1'b0, idx} < IDX_LIMIT);
  assign wr_fire = we && !run_en && idx_ok;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        words[g] <= '0;
      else if (wr_fire && (idx == CTX_W'(g)))
        words[g] <= wdata;
    end
  end
endmodule

// File: rtl/ctx_counter.sv
module ctx_counter
  import ctx_plane_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             used_we,
  input  logic [CNT_W-1:0] used_val,
  output logic [CTX_W-1:0] ctx,
  output logic [CNT_W-1:0] used_cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] used_next;

  assign used_next = CNT_W'(clamp_used(int'(used_val), NUM_CTX));
  assign wrap      = is_last(int'(ctx), int'(used_cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      used_cnt <= CNT_W'(NUM_CTX);
      ctx      <= '0;
    end else if (used_we) begin
      used_cnt <= used_next;
      ctx      <= '0;
    end else if (run_en) begin
      ctx <= wrap ? '0 : ctx + CTX_W'(1);
    end
  end
endmodule

// File: rtl/ctx_onehot.sv
module ctx_onehot #(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2,
  parameter int CNT_W   = 3
) (
  input  logic [CTX_W-1:0]   ctx,
  input  logic [CNT_W-1:0]   used_cnt,
  output logic [NUM_CTX-1:0] sel
);
  for (genvar g = 0; g < NUM_CTX; g++) begin : g_sel
    assign sel[g] = (ctx == CTX_W'(g)) && (CNT_W'(g) < used_cnt);
  end
endmodule

// File: rtl/ctx_andor.sv
module ctx_andor #(
  parameter int NUM_CTX = 4,
  parameter int CFG_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CTX-1:0][CFG_W-1:0] words,
  input  logic [NUM_CTX-1:0]            sel,
  output logic [CFG_W-1:0]              cfg_out
);
  logic [CFG_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_CTX; i++)
      picked = picked | (words[i] & {CFG_W{sel[i]}});
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_out <= '0;
    else     cfg_out <= picked;
  end
endmodule

// File: rtl/ctx_plane_sel.sv
module ctx_plane_sel #(
  parameter int NUM_CTX = 4,
  parameter int CFG_W   = 16,
  parameter int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  parameter int CNT_W   = $clog2(NUM_CTX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             ld_we,
  input  logic [CTX_W-1:0] ld_ctx,
  input  logic [CFG_W-1:0] ld_word,
  input  logic             used_we,
  input  logic [CNT_W-1:0] used_val,
  output logic [CTX_W-1:0] ctx_code,
  output logic [CFG_W-1:0] cfg_out
);
  logic [NUM_CTX-1:0][CFG_W-1:0] words;
  logic                          wr_fire;
  logic [CNT_W-1:0]              used_cnt;
  logic                          wrap;
  logic [NUM_CTX-1:0]            sel_oh;

  ctx_store #(.NUM_CTX(NUM_CTX), .CFG_W(CFG_W), .CTX_W(CTX_W)) u_store (
    .clk(clk), .rst(rst), .we(ld_we), .run_en(run_en), .idx(ld_ctx),
    .wdata(ld_word), .words(words), .wr_fire(wr_fire)
  );

  ctx_counter #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run_en(run_en), .used_we(used_we),
    .used_val(used_val), .ctx(ctx_code), .used_cnt(used_cnt), .wrap(wrap)
  );

  ctx_onehot #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .CNT_W(CNT_W)) u_oh (
    .ctx(ctx_code), .used_cnt(used_cnt), .sel(sel_oh)
  );

  ctx_andor #(.NUM_CTX(NUM_CTX), .CFG_W(CFG_W)) u_mux (
    .clk(clk), .rst(rst), .words(words), .sel(sel_oh), .cfg_out(cfg_out)
  );
endmodule

// File: rtl/ctx_plane_sel_chk.sv
module ctx_plane_sel_chk #(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               run_en,
  input logic               used_we,
  input logic               wr_fire,
  input logic               wrap,
  input logic [CTX_W-1:0]   ctx_code,
  input logic [CNT_W-1:0]   used_cnt,
  input logic [NUM_CTX-1:0] sel_oh
);
  // R12
  ctx_below_used_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, ctx_code} < (CTX_W+1)'(used_cnt));

  // R12
  one_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_oh) == 1);

  // R6
  used_range_chk: assert property (@(posedge clk) disable iff (rst)
    (used_cnt != '0) && (used_cnt <= CNT_W'(NUM_CTX)));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    used_we |=> (ctx_code == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !used_we) |=> $stable(ctx_code));

  // R9
  no_run_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> !run_en);

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && wrap) |=> (ctx_code == '0));
endmodule

bind ctx_plane_sel ctx_plane_sel_chk #(
  .NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .used_we(used_we),
  .wr_fire(wr_fire), .wrap(wrap), .ctx_code(ctx_code),
  .used_cnt(used_cnt), .sel_oh(sel_oh)
);

// File: tb/ctx_plane_sel_tb.sv
module ctx_plane_sel_tb;
  localparam int N     = 6;
  localparam int CFG_W = 16;
  localparam int CTX_W = 3;
  localparam int CNT_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             run_en = 1'b0;
  logic             ld_we = 1'b0;
  logic [CTX_W-1:0] ld_ctx = '0;
  logic [CFG_W-1:0] ld_word = '0;
  logic             used_we = 1'b0;
  logic [CNT_W-1:0] used_val = '0;
  logic [CTX_W-1:0] ctx_code;
  logic [CFG_W-1:0] cfg_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int ctx_m = 0;
  int used_m = N;
  logic [CFG_W-1:0] cfg_m = '0;
  logic [CFG_W-1:0] word_m [N];

  always #2 clk = ~clk;

  ctx_plane_sel #(.NUM_CTX(N), .CFG_W(CFG_W)) u_dut (
    .clk(clk), .rst(rst), .run_en(run_en), .ld_we(ld_we), .ld_ctx(ld_ctx),
    .ld_word(ld_word), .used_we(used_we), .used_val(used_val),
    .ctx_code(ctx_code), .cfg_out(cfg_out)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected behaviour per clock, taken from the requirements
  task automatic tick();
    int old = ctx_m;
    cfg_m = word_m[old];                                   // R11
    if (ld_we && !run_en && int'(ld_ctx) < N)              // R2 R9 R10
      word_m[int'(ld_ctx)] = ld_word;
    if (used_we) begin                                     // R6 R7
      used_m = (used_val == 0) ? 1 : ((int'(used_val) > N) ? N : int'(used_val));
      ctx_m = 0;
    end else if (run_en) begin
      ctx_m = (ctx_m + 1) % used_m;                        // R3 R4
    end
    @(posedge clk);
    #1;
  endtask

  task automatic state_chk(string req);
    chk({req, " ctx"}, int'(ctx_code), ctx_m);
    chk({req, " cfg"}, int'(cfg_out), int'(cfg_m));
  endtask

  task automatic load(int idx, logic [CFG_W-1:0] w);
    ld_we = 1'b1; ld_ctx = CTX_W'(idx); ld_word = w;
    tick();
    ld_we = 1'b0;
  endtask

  task automatic set_used(int v);
    used_we = 1'b1; used_val = CNT_W'(v);
    tick();
    used_we = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b0;
    ctx_m = 0; used_m = N; cfg_m = '0;
    for (int i = 0; i < N; i++) word_m[i] = '0;
    state_chk("R1 reset");
    tick();
    state_chk("R1 cleared words");
  endtask

  task automatic t_load();
    for (int i = 0; i < N; i++) load(i, CFG_W'(16'hA000 + i * 16'h0111));
    load(6, 16'hDEAD);                                     // R10
    load(7, 16'hBEEF);                                     // R10
    tick();
    state_chk("R2 word of ctx 0");
  endtask

  task automatic t_full();
    run_en = 1'b1;
    for (int i = 0; i < 2 * N + 1; i++) begin
      tick();
      state_chk("R3 R10 R11 full cycle");
    end
    run_en = 1'b0;
  endtask

  task automatic t_modulo();
    set_used(3);
    state_chk("R7 restart at 0");
    run_en = 1'b1;
    for (int i = 0; i < 7; i++) begin
      tick();
      state_chk("R4 R12 modulo 3");
    end
    run_en = 1'b0;
  endtask

  task automatic t_restart_running();
    run_en = 1'b1;
    tick();
    used_we = 1'b1; used_val = 3'd4;
    tick();
    used_we = 1'b0;
    state_chk("R7 restart while running");
    for (int i = 0; i < 6; i++) begin
      tick();
      state_chk("R4 modulo 4");
    end
    run_en = 1'b0;
  endtask

  task automatic t_one_and_zero();
    set_used(1);
    run_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      state_chk("R5 single context");
    end
    run_en = 1'b0;
    set_used(0);
    run_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      state_chk("R6 zero as one");
    end
    run_en = 1'b0;
  endtask

  task automatic t_clamp();
    set_used(7);
    run_en = 1'b1;
    for (int i = 0; i < N + 2; i++) begin
      tick();
      state_chk("R6 clamp to max");
    end
    run_en = 1'b0;
  endtask

  task automatic t_hold();
    run_en = 1'b1;
    tick(); tick();
    run_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      state_chk("R8 hold");
    end
  endtask

  task automatic t_write_while_running();
    run_en = 1'b1;
    ld_we = 1'b1; ld_ctx = 3'd2; ld_word = 16'h5A5A;
    tick(); tick();
    ld_we = 1'b0;
    for (int i = 0; i < N; i++) begin
      tick();
      state_chk("R9 write ignored while running");
    end
    chk("R9 model word 2 kept", int'(word_m[2]), int'(16'hA000 + 2 * 16'h0111));
    run_en = 1'b0;
  endtask

  task automatic t_reload_idle();
    set_used(6);
    load(0, 16'h1234);
    tick();
    state_chk("R2 reload ctx 0");
    run_en = 1'b1;
    tick();
    run_en = 1'b0;
    load(1, 16'h4321);
    tick();
    state_chk("R2 reload ctx 1");
  endtask

  initial begin
    t_reset();
    t_load();
    t_full();
    t_modulo();
    t_restart_running();
    t_one_and_zero();
    t_clamp();
    t_hold();
    t_write_while_running();
    t_reload_idle();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule